// File: doc/BRIEF.md
# Multi-Slot Read Request Matcher

This block sits beside the bus protocol engine of an I3C target that serves several virtual targets. When the engine has decoded the header of an incoming read, it presents the request: the addressed target, the kind of read (SDR private read, HDR private read carrying a command code, or a directed vendor-specific CCC read with its CCC code and an optional defining byte). The block compares that request against a small set of programmed read-response command slots. Each slot is paired with its own transmit FIFO.

One clock after the request strobe, the block reports a single outcome. It either acknowledges the read and names the slot that will supply the data, or it refuses the read. A refusal carries one of two causes: no programmed command matched, or the matching slot has no data ready. The protocol engine uses the outcome to drive ACK or NACK on the bus. Software uses the cause flags as status. The FIFOs, register decoding and the bus state machine are outside this block.

Top module: `rd_match_top`

## Requirements
- R1: A slot can match only when its programmed address field equals `req_addr`. Slot i uses bits [i*ADDR_W +: ADDR_W] of `slot_addr`, and the same packing at byte width applies to `slot_hdr` and `slot_db`.
- R2: A slot with `slot_ccc_sel`=0 and header field 0x00 matches only a request of kind 0 (SDR private read).
- R3: A slot with `slot_ccc_sel`=0 and a nonzero header field matches only a request of kind 1 (HDR private read) whose `req_code` equals the header field.
- R4: A slot with `slot_ccc_sel`=1 matches only a request of kind 2 (directed CCC read) whose `req_code` equals the header field and, when `req_has_db`=1, whose `req_db` equals the slot's defining byte. Kind 3 matches no slot.
- R5: A CCC request sent without a defining byte (`req_has_db`=0) matches a CCC slot only if that slot's defining byte is 0x00. The value on `req_db` is then ignored.
- R6: Only slots with their `slot_valid` bit set take part in matching.
- R7: When several valid slots match, the lowest-numbered one is selected, and only its FIFO state is considered.
- R8: The read is acknowledged (`rsp_ack`=1) only when a slot is selected and its `slot_fifo_empty` bit is 0. `rsp_slot` then gives the selected slot index.
- R9: When no valid slot matches, the read is refused with `rsp_no_cmd`=1 and `rsp_slot`=0.
- R10: When the selected slot's FIFO is empty, the read is refused with `rsp_not_ready`=1, and `rsp_slot` gives that slot.
- R11: `rsp_valid` is high exactly in the cycle after a `req_valid` cycle. In that cycle exactly one of `rsp_ack`, `rsp_no_cmd` and `rsp_not_ready` is high. All four are low in any other cycle.
- R12: After reset, all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle strobe: a decoded read request is present |
| req_addr | input | ADDR_W | Addressed target |
| req_kind | input | 2 | 0 SDR private, 1 HDR private, 2 directed CCC, 3 reserved |
| req_code | input | 8 | HDR command code or CCC code |
| req_has_db | input | 1 | CCC carries a defining byte |
| req_db | input | 8 | Defining byte of the CCC |
| slot_valid | input | N_SLOTS | Per-slot command valid |
| slot_addr | input | N_SLOTS*ADDR_W | Per-slot virtual target address |
| slot_ccc_sel | input | N_SLOTS | Per-slot CCC select |
| slot_hdr | input | N_SLOTS*8 | Per-slot header field (HDR code or CCC code) |
| slot_db | input | N_SLOTS*8 | Per-slot defining byte |
| slot_fifo_empty | input | N_SLOTS | Per-slot transmit FIFO empty |
| rsp_valid | output | 1 | Outcome present |
| rsp_ack | output | 1 | Read accepted |
| rsp_slot | output | IDX_W | Selected slot index |
| rsp_no_cmd | output | 1 | Refused: no matching command |
| rsp_not_ready | output | 1 | Refused: matching slot has no data |

## Verification
The directed cases target the places where a matcher is most easily wrong. A CCC sent without a defining byte must hit a slot whose defining byte is zero and must miss one whose defining byte is nonzero. A design that compared `req_db` regardless would accept or reject by chance. A zero header must separate SDR reads from HDR reads; a design that ignored it would answer an HDR read from an SDR slot. When a lower matching slot has an empty FIFO and a higher matching slot holds data, the design must still refuse with the data-not-ready cause. A design that skipped to the next slot would acknowledge and return the wrong data. Random requests drawn from small value pools then exercise matches on several slots at once, invalid slots and both refusal causes.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

  localparam int unsigned RD_BYTE_W = 8;

  typedef enum logic [1:0] {
    RK_SDR  = 2'd0,
    RK_HDR  = 2'd1,
    RK_CCC  = 2'd2,
    RK_RSVD = 2'd3
  } rd_kind_e;

  // Decide whether a slot's transfer-type fields accept the request kind.
  function automatic logic kind_accepts(
    input logic                 ccc_sel,
    input logic [RD_BYTE_W-1:0] hdr,
    input logic [RD_BYTE_W-1:0] sdb,
    input rd_kind_e             kind,
    input logic [RD_BYTE_W-1:0] code,
    input logic                 has_db,
    input logic [RD_BYTE_W-1:0] rdb
  );
    logic db_ok;
    db_ok = has_db ? (rdb == sdb) : (sdb == '0);
    if (ccc_sel)
      return (kind == RK_CCC) && (code == hdr) && db_ok;
    else if (hdr == '0)
      return (kind == RK_SDR);
    else
      return (kind == RK_HDR) && (code == hdr);
  endfunction

endpackage

// File: rtl/rdm_slot_cmp.sv
module rdm_slot_cmp
  import rdm_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic                 valid,
  input  logic [ADDR_W-1:0]    s_addr,
  input  logic                 s_ccc_sel,
  input  logic [RD_BYTE_W-1:0] s_hdr,
  input  logic [RD_BYTE_W-1:0] s_db,
  input  logic [ADDR_W-1:0]    r_addr,
  input  rd_kind_e             r_kind,
  input  logic [RD_BYTE_W-1:0] r_code,
  input  logic                 r_has_db,
  input  logic [RD_BYTE_W-1:0] r_db,
  output logic                 hit
);
  logic addr_eq;
  logic type_ok;

  assign addr_eq = (s_addr == r_addr);
  assign type_ok = kind_accepts(s_ccc_sel, s_hdr, s_db, r_kind, r_code, r_has_db, r_db);
  assign hit     = valid && addr_eq && type_ok;
endmodule

// File: rtl/rdm_first_hit.sv
module rdm_first_hit #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     hits,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rd_match_top.sv
module rd_match_top
  import rdm_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned ADDR_W  = 7,
  localparam int unsigned IDX_W  = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int unsigned BW     = RD_BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_kind,
  input  logic [BW-1:0]             req_code,
  input  logic                      req_has_db,
  input  logic [BW-1:0]             req_db,
  input  logic [N_SLOTS-1:0]        slot_valid,
  input  logic [N_SLOTS*ADDR_W-1:0] slot_addr,
  input  logic [N_SLOTS-1:0]        slot_ccc_sel,
  input  logic [N_SLOTS*BW-1:0]     slot_hdr,
  input  logic [N_SLOTS*BW-1:0]     slot_db,
  input  logic [N_SLOTS-1:0]        slot_fifo_empty,
  output logic                      rsp_valid,
  output logic                      rsp_ack,
  output logic [IDX_W-1:0]          rsp_slot,
  output logic                      rsp_no_cmd,
  output logic                      rsp_not_ready
);

  // Named internal events for the checker.
  logic [N_SLOTS-1:0] hit_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   pick_idx;
  logic               pick_empty;

  rd_kind_e kind_in;
  assign kind_in = rd_kind_e'(req_kind);

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    rdm_slot_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .valid     (slot_valid[g]),
      .s_addr    (slot_addr[g*ADDR_W +: ADDR_W]),
      .s_ccc_sel (slot_ccc_sel[g]),
      .s_hdr     (slot_hdr[g*BW +: BW]),
      .s_db      (slot_db[g*BW +: BW]),
      .r_addr    (req_addr),
      .r_kind    (kind_in),
      .r_code    (req_code),
      .r_has_db  (req_has_db),
      .r_db      (req_db),
      .hit       (hit_vec[g])
    );
  end

  rdm_first_hit #(.N(N_SLOTS), .IDX_W(IDX_W)) u_pick (
    .hits  (hit_vec),
    .found (any_hit),
    .idx   (pick_idx)
  );

  assign pick_empty = slot_fifo_empty[pick_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_ack       <= 1'b0;
      rsp_slot      <= '0;
      rsp_no_cmd    <= 1'b0;
      rsp_not_ready <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_ack       <= req_valid && any_hit && !pick_empty;
      rsp_not_ready <= req_valid && any_hit && pick_empty;
      rsp_no_cmd    <= req_valid && !any_hit;
      rsp_slot      <= (req_valid && any_hit) ? pick_idx : '0;
    end
  end

endmodule

// File: rtl/rd_match_chk.sv
module rd_match_chk #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [N-1:0]     slot_valid,
  input logic [N-1:0]     slot_fifo_empty,
  input logic [N-1:0]     hit_vec,
  input logic             rsp_valid,
  input logic             rsp_ack,
  input logic [IDX_W-1:0] rsp_slot,
  input logic             rsp_no_cmd,
  input logic             rsp_not_ready
);
  logic [N-1:0] hit_q, empty_q, valid_q;
  logic [N-1:0] below_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= '0;
      empty_q <= '0;
      valid_q <= '0;
    end else begin
      hit_q   <= hit_vec;
      empty_q <= slot_fifo_empty;
      valid_q <= slot_valid;
    end
  end

  assign below_mask = (N'(1) << rsp_slot) - N'(1);

  p_resp_follows_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_ack && !rsp_no_cmd && !rsp_not_ready);
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_ack, rsp_no_cmd, rsp_not_ready}) == 1);
  p_ack_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |-> !empty_q[rsp_slot]);
  p_slot_is_valid_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack || rsp_not_ready) |-> hit_q[rsp_slot] && valid_q[rsp_slot]);
  p_lowest_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ack || rsp_not_ready) |-> (hit_q & below_mask) == '0);
  p_not_ready_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_not_ready |-> empty_q[rsp_slot]);
  p_no_cmd_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_no_cmd |-> hit_q == '0 && rsp_slot == '0);
endmodule

bind rd_match_top rd_match_chk #(.N(N_SLOTS), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .slot_valid      (slot_valid),
  .slot_fifo_empty (slot_fifo_empty),
  .hit_vec         (hit_vec),
  .rsp_valid       (rsp_valid),
  .rsp_ack         (rsp_ack),
  .rsp_slot        (rsp_slot),
  .rsp_no_cmd      (rsp_no_cmd),
  .rsp_not_ready   (rsp_not_ready)
);

// File: tb/rd_match_top_test.sv
`timescale 1ns/1ps
module rd_match_top_test;
  localparam int N = 4;
  localparam int AW = 7;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_kind = '0;
  logic [7:0] req_code = '0, req_db = '0;
  logic req_has_db = 0;
  logic [N-1:0] slot_valid = '0, slot_ccc_sel = '0, slot_fifo_empty = '0;
  logic [N*AW-1:0] slot_addr = '0;
  logic [N*8-1:0] slot_hdr = '0, slot_db = '0;
  logic rsp_valid, rsp_ack, rsp_no_cmd, rsp_not_ready;
  logic [1:0] rsp_slot;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rd_match_top #(.N_SLOTS(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .req_code(req_code), .req_has_db(req_has_db), .req_db(req_db),
    .slot_valid(slot_valid), .slot_addr(slot_addr), .slot_ccc_sel(slot_ccc_sel),
    .slot_hdr(slot_hdr), .slot_db(slot_db), .slot_fifo_empty(slot_fifo_empty),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_slot(rsp_slot),
    .rsp_no_cmd(rsp_no_cmd), .rsp_not_ready(rsp_not_ready));

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bench model of one slot's match rule.
  function automatic bit model_hit(input int i);
    bit [7:0] h, d;
    bit dbok;
    h = slot_hdr[i*8 +: 8];
    d = slot_db[i*8 +: 8];
    if (!slot_valid[i]) return 0;
    if (slot_addr[i*AW +: AW] != req_addr) return 0;
    if (slot_ccc_sel[i]) begin
      if (req_has_db) dbok = (req_db == d);
      else            dbok = (d == 8'h00);
      return req_kind == 2 && req_code == h && dbok;
    end
    if (h == 8'h00) return req_kind == 0;
    return req_kind == 1 && req_code == h;
  endfunction

  task automatic set_slot(input int i, input bit v, input int a, input bit cs,
                          input int h, input int d, input bit e);
    slot_valid[i] = v;
    slot_addr[i*AW +: AW] = AW'(a);
    slot_ccc_sel[i] = cs;
    slot_hdr[i*8 +: 8] = 8'(h);
    slot_db[i*8 +: 8] = 8'(d);
    slot_fifo_empty[i] = e;
  endtask

  // Issue one request and compare with the model; outputs sampled at negedge.
  task automatic run_req(input string tag, input int a, input int k, input int c,
                         input bit hdb, input int d);
    int exp_slot; bit found, emp;
    req_addr = AW'(a); req_kind = 2'(k); req_code = 8'(c);
    req_has_db = hdb; req_db = 8'(d); req_valid = 1;
    found = 0; exp_slot = 0;
    for (int i = N - 1; i >= 0; i--)
      if (model_hit(i)) begin found = 1; exp_slot = i; end
    emp = found ? slot_fifo_empty[exp_slot] : 0;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " valid"}, int'(rsp_valid), 1);
    chk({tag, " ack"}, int'(rsp_ack), int'(found && !emp));
    chk({tag, " no_cmd"}, int'(rsp_no_cmd), int'(!found));
    chk({tag, " not_ready"}, int'(rsp_not_ready), int'(found && emp));
    chk({tag, " slot"}, int'(rsp_slot), exp_slot);
    @(negedge clk);
    chk({tag, " idle R11"}, int'(rsp_valid | rsp_ack | rsp_no_cmd | rsp_not_ready), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R12 reset valid", int'(rsp_valid), 0);
    chk("R12 reset flags", int'(rsp_ack | rsp_no_cmd | rsp_not_ready), 0);
    chk("R12 reset slot", int'(rsp_slot), 0);
    rst_n = 1;
    @(negedge clk);

    // Directed cases
    set_slot(0, 1, 8'h10, 0, 8'h00, 0, 0);
    set_slot(1, 1, 8'h11, 0, 8'h5A, 0, 0);
    set_slot(2, 1, 8'h12, 1, 8'hD0, 8'h00, 0);
    set_slot(3, 1, 8'h13, 1, 8'hD1, 8'h44, 0);
    run_req("R2 sdr hit", 8'h10, 0, 0, 0, 0);
    run_req("R2 sdr slot rejects hdr", 8'h10, 1, 8'h5A, 0, 0);
    run_req("R1 wrong addr", 8'h15, 0, 0, 0, 0);
    run_req("R3 hdr hit", 8'h11, 1, 8'h5A, 0, 0);
    run_req("R3 hdr wrong code", 8'h11, 1, 8'h5B, 0, 0);
    run_req("R3 hdr slot rejects sdr", 8'h11, 0, 0, 0, 0);
    run_req("R4 ccc hit db", 8'h13, 2, 8'hD1, 1, 8'h44);
    run_req("R4 ccc wrong db", 8'h13, 2, 8'hD1, 1, 8'h45);
    run_req("R4 ccc wrong code", 8'h13, 2, 8'hD2, 1, 8'h44);
    run_req("R4 reserved kind", 8'h13, 3, 8'hD1, 1, 8'h44);
    run_req("R5 zero db matches none", 8'h12, 2, 8'hD0, 0, 8'h99);
    run_req("R5 zero db matches zero", 8'h12, 2, 8'hD0, 1, 8'h00);
    run_req("R5 nonzero db needs byte", 8'h13, 2, 8'hD1, 0, 8'h44);
    slot_valid[0] = 0;
    run_req("R6 invalid slot ignored", 8'h10, 0, 0, 0, 0);
    // Priority: slots 1 and 3 both SDR on same address
    set_slot(1, 1, 8'h20, 0, 8'h00, 0, 0);
    set_slot(3, 1, 8'h20, 0, 8'h00, 0, 0);
    run_req("R7 lowest wins", 8'h20, 0, 0, 0, 0);
    slot_fifo_empty[1] = 1;
    run_req("R10 lower empty no skip", 8'h20, 0, 0, 0, 0);
    set_slot(1, 0, 8'h20, 0, 8'h00, 0, 1);
    run_req("R8 higher slot acks", 8'h20, 0, 0, 0, 0);
    slot_valid = '0;
    run_req("R9 no command", 8'h20, 0, 0, 0, 0);

    // Back-to-back strobes: response tracks each one
    set_slot(0, 1, 8'h30, 0, 8'h00, 0, 0);
    req_addr = 8'h30; req_kind = 0; req_valid = 1;
    @(negedge clk);
    chk("R11 b2b first", int'(rsp_ack), 1);
    req_addr = 8'h31;
    @(negedge clk);
    req_valid = 0;
    chk("R11 b2b second", int'(rsp_no_cmd), 1);
    @(negedge clk);

    // Random requests from small value pools
    for (int n = 0; n < 600; n++) begin
      for (int i = 0; i < N; i++)
        set_slot(i, bit'($urandom_range(0, 3) != 0), 8'h40 + $urandom_range(0, 2),
                 bit'($urandom_range(0, 1)),
                 ($urandom_range(0, 2) == 0) ? 0 : 8'hA0 + $urandom_range(0, 2),
                 ($urandom_range(0, 1) == 0) ? 0 : 8'h70 + $urandom_range(0, 1),
                 bit'($urandom_range(0, 3) == 0));
      run_req("R8 random", 8'h40 + $urandom_range(0, 2), $urandom_range(0, 3),
              ($urandom_range(0, 3) == 0) ? 0 : 8'hA0 + $urandom_range(0, 2),
              bit'($urandom_range(0, 1)),
              ($urandom_range(0, 1) == 0) ? 0 : 8'h70 + $urandom_range(0, 1));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule